// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine places received frame bytes into host buffers described by a ring of descriptors. The descriptors sit in a small store inside the block that the host reads and writes word by word. Each descriptor carries a 16-bit status, a 16-bit byte count and a 32-bit buffer address. The host prepares the ring by marking descriptors as free for the engine and setting the last one as the ring end. It then starts the engine with an activation write. Bytes arrive one per cycle with start-of-frame, end-of-frame and error qualifiers. Each accepted byte goes out on a byte-write port at the buffer address plus its offset.

When a buffer fills, or a frame ends, the engine writes the status and count back into the descriptor. This writeback lands on the same clock edge as the final byte write of that buffer. The engine then hands the descriptor to the host and steps to the next descriptor, returning to the ring start after the ring-end descriptor. A long frame therefore spans several buffers, and only the buffer holding the frame end is flagged as last. If the engine finds a descriptor still owned by the host, it stops. It then drops bytes and flags an overflow until the host activates it again.

Top module: `rxring_engine`

## Requirements
- R1: Descriptor word 0 is {status[15:0], count[15:0]} and word 1 is the buffer address. The host selects a word with host_addr = {descriptor index, word bit}: writes take effect at the next edge, and reads are combinational. Status bit 15 is FREE (engine owns the buffer), bit 13 is RING_END, bit 11 is LAST and bit 0 is BAD.
- R2: An activation write (act_wr with act_data bit 24 set) makes active_o 1 and clears evt_overflow at the next edge. The first activation after reset also loads the current descriptor index from cfg_ring_start.
- R3: A byte is accepted only while the engine is active, the current descriptor has FREE set, and either a frame is open or in_sof is set. In the same cycle, buf_we is 1, buf_addr equals the buffer address plus the byte offset in that buffer, and buf_wdata equals in_data. A byte arriving with no open frame and no in_sof is ignored without any event.
- R4: When the count in a buffer reaches cfg_buf_size without in_eof, the descriptor is written back with FREE and LAST clear and count = cfg_buf_size. evt_buf pulses for one cycle, and the frame continues in the next descriptor.
- R5: On an accepted in_eof byte, the descriptor is written back with FREE clear and LAST set. Its count includes every byte of the frame held in that buffer, including the 4 trailing check bytes delivered by the receive path. evt_frame pulses for one cycle, and it never pulses together with evt_buf.
- R6: If in_err accompanies any accepted byte of a frame, BAD is set on the descriptor carrying LAST for that frame. Otherwise BAD is clear.
- R7: After writing back a descriptor whose RING_END bit is set, the engine moves to cfg_ring_start; otherwise it moves to the next index. RING_END and the buffer address survive the writeback.
- R8: While active, finding the current descriptor without FREE clears active_o at the next edge. No byte is written while active_o is 0.
- R9: Any in_valid byte that the engine cannot place because it is inactive or has no free buffer sets evt_overflow from the next edge. evt_overflow holds until an activation write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_start | input | IDX_W | Index of the first ring descriptor |
| cfg_buf_size | input | 16 | Bytes per buffer |
| act_wr | input | 1 | Write strobe of the activation register |
| act_data | input | 32 | Activation data; bit 24 starts polling |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | IDX_W+1 | {descriptor index, word select} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Byte belongs to a bad frame |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| evt_frame | output | 1 | Frame-completed pulse |
| evt_buf | output | 1 | Buffer-filled pulse |
| evt_overflow | output | 1 | Bytes lost, held until activation |
| active_o | output | 1 | Engine polling state |

## Verification
The bench keeps the default depth of 8 descriptors and builds a four-entry ring at indices 2 to 5, with cfg_buf_size set to 8. A ring that does not start at index 0 shows that the start register is used. A ring-end descriptor at index 5 shows that the engine returns to index 2 rather than stepping to index 6. The 8-byte buffer lets an 11-byte frame span two buffers, so both the split path and the last-buffer path are exercised in a short run. Filling every ring entry brings the engine back to a descriptor the host still owns, which covers the stall, the overflow flag and reactivation.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int STAT_W   = 16;
  localparam int CNT_W    = 16;
  localparam int PTR_W    = 32;
  localparam int ST_FREE  = 15;
  localparam int ST_END   = 13;
  localparam int ST_LAST  = 11;
  localparam int ST_BAD   = 0;
  localparam int ACT_BIT  = 24;

  typedef struct packed {
    logic [STAT_W-1:0] status;
    logic [CNT_W-1:0]  count;
    logic [PTR_W-1:0]  ptr;
  } rxdesc_t;
endpackage

// File: rtl/rxring_store.sv
module rxring_store
  import rxring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [IDX_W:0]       host_addr,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  input  logic [IDX_W-1:0]     rd_idx,
  output rxdesc_t              rd_desc,
  input  logic                 eng_we,
  input  logic [IDX_W-1:0]     eng_idx,
  input  logic [STAT_W-1:0]    eng_status,
  input  logic [CNT_W-1:0]     eng_count
);
  rxdesc_t                 ent [DEPTH];
  logic [IDX_W-1:0]        host_idx;
  rxdesc_t                 host_ent;

  assign host_idx = host_addr[IDX_W:1];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rxdesc_t q;
    logic    eng_hit;
    logic    host_hit;
    assign eng_hit  = eng_we  && (eng_idx  == IDX_W'(g));
    assign host_hit = host_we && (host_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (eng_hit) begin
        q.status <= eng_status;
        q.count  <= eng_count;
      end else if (host_hit) begin
        if (host_addr[0]) q.ptr <= host_wdata;
        else              {q.status, q.count} <= host_wdata;
      end
    end
    assign ent[g] = q;
  end

  assign rd_desc    = ent[rd_idx];
  assign host_ent   = ent[host_idx];
  assign host_rdata = host_addr[0] ? host_ent.ptr : {host_ent.status, host_ent.count};
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   cfg_ring_start,
  input  logic [CNT_W-1:0]   cfg_buf_size,
  input  logic               act_wr,
  input  logic [31:0]        act_data,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_err,
  input  rxdesc_t            cur_desc,
  output logic [IDX_W-1:0]   cur_idx,
  output logic               eng_we,
  output logic [STAT_W-1:0]  eng_status,
  output logic [CNT_W-1:0]   eng_count,
  output logic               buf_we,
  output logic [PTR_W-1:0]   buf_addr,
  output logic [7:0]         buf_wdata,
  output logic               evt_frame,
  output logic               evt_buf,
  output logic               evt_overflow,
  output logic               active_o
);
  logic             active_q, active_d;
  logic             started_q, started_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             bad_q, bad_d;
  logic             fev_q, fev_d;
  logic             bev_q, bev_d;
  logic             ovf_q, ovf_d;

  logic             act_hit, owns, take, drop, close, frame_bad;
  logic [CNT_W-1:0] cnt_use, fill;
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    act_hit   = act_wr && act_data[ACT_BIT];
    owns      = active_q && cur_desc.status[ST_FREE];
    take      = in_valid && owns && (open_q || in_sof);
    drop      = in_valid && !owns;
    cnt_use   = in_sof ? '0 : cnt_q;
    fill      = cnt_use + 1'b1;
    close     = take && (in_eof || (fill == cfg_buf_size));
    frame_bad = in_err || (bad_q && !in_sof);
    idx_next  = cur_desc.status[ST_END] ? cfg_ring_start : idx_q + 1'b1;

    eng_we               = close;
    eng_count            = fill;
    eng_status           = cur_desc.status;
    eng_status[ST_FREE]  = 1'b0;
    eng_status[ST_LAST]  = in_eof;
    eng_status[ST_BAD]   = in_eof && frame_bad;

    buf_we    = take;
    buf_addr  = cur_desc.ptr + PTR_W'(cnt_use);
    buf_wdata = in_data;
  end

  always_comb begin
    active_d  = active_q;
    started_d = started_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    open_d    = open_q;
    bad_d     = bad_q;
    ovf_d     = ovf_q;
    if (active_q && !cur_desc.status[ST_FREE]) active_d = 1'b0;
    if (take) begin
      cnt_d  = close ? '0 : fill;
      open_d = !in_eof;
      bad_d  = in_eof ? 1'b0 : frame_bad;
    end else if (drop) begin
      open_d = 1'b0;
      bad_d  = 1'b0;
    end
    if (close) idx_d = idx_next;
    if (drop)  ovf_d = 1'b1;
    if (act_hit) begin
      active_d = 1'b1;
      ovf_d    = 1'b0;
      if (!started_q) begin
        started_d = 1'b1;
        idx_d     = cfg_ring_start;
      end
    end
    fev_d = close && in_eof;
    bev_d = close && !in_eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      started_q <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= '0;
      open_q    <= 1'b0;
      bad_q     <= 1'b0;
      fev_q     <= 1'b0;
      bev_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      active_q  <= active_d;
      started_q <= started_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      open_q    <= open_d;
      bad_q     <= bad_d;
      fev_q     <= fev_d;
      bev_q     <= bev_d;
      ovf_q     <= ovf_d;
    end
  end

  assign cur_idx      = idx_q;
  assign evt_frame    = fev_q;
  assign evt_buf      = bev_q;
  assign evt_overflow = ovf_q;
  assign active_o     = active_q;
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   cfg_ring_start,
  input  logic [15:0]        cfg_buf_size,
  input  logic               act_wr,
  input  logic [31:0]        act_data,
  input  logic               host_we,
  input  logic [IDX_W:0]     host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_err,
  output logic               buf_we,
  output logic [31:0]        buf_addr,
  output logic [7:0]         buf_wdata,
  output logic               evt_frame,
  output logic               evt_buf,
  output logic               evt_overflow,
  output logic               active_o
);
  rxdesc_t             cur_desc;
  logic [IDX_W-1:0]    cur_idx;
  logic                eng_we;
  logic [STAT_W-1:0]   eng_status;
  logic [CNT_W-1:0]    eng_count;

  rxring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rd_idx     (cur_idx),
    .rd_desc    (cur_desc),
    .eng_we     (eng_we),
    .eng_idx    (cur_idx),
    .eng_status (eng_status),
    .eng_count  (eng_count)
  );

  rxring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_ring_start (cfg_ring_start),
    .cfg_buf_size   (cfg_buf_size),
    .act_wr         (act_wr),
    .act_data       (act_data),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_sof         (in_sof),
    .in_eof         (in_eof),
    .in_err         (in_err),
    .cur_desc       (cur_desc),
    .cur_idx        (cur_idx),
    .eng_we         (eng_we),
    .eng_status     (eng_status),
    .eng_count      (eng_count),
    .buf_we         (buf_we),
    .buf_addr       (buf_addr),
    .buf_wdata      (buf_wdata),
    .evt_frame      (evt_frame),
    .evt_buf        (evt_buf),
    .evt_overflow   (evt_overflow),
    .active_o       (active_o)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        act_wr,
  input logic [31:0] act_data,
  input logic        in_valid,
  input logic        in_eof,
  input logic        buf_we,
  input logic        evt_frame,
  input logic        evt_buf,
  input logic        evt_overflow,
  input logic        active_o
);
  AST_ACT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wr && act_data[24]) |=> (active_o && !evt_overflow)); // R2

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !buf_we); // R8

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_frame && evt_buf)); // R4

  AST_FRAME_FROM_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame |-> $past(in_valid && in_eof)); // R5

  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !active_o && !act_wr) |=> evt_overflow); // R9

  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_overflow && !act_wr) |=> evt_overflow); // R9
endmodule

bind rxring_engine rxring_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .act_wr       (act_wr),
  .act_data     (act_data),
  .in_valid     (in_valid),
  .in_eof       (in_eof),
  .buf_we       (buf_we),
  .evt_frame    (evt_frame),
  .evt_buf      (evt_buf),
  .evt_overflow (evt_overflow),
  .active_o     (active_o)
);

// File: tb/rxring_engine_bench.sv
module rxring_engine_bench;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int BSZ   = 8;

  // frame table: {bad flag, length}
  localparam logic [16:0] FR [3] = '{ {1'b0, 16'd6}, {1'b0, 16'd11}, {1'b1, 16'd2} };
  // expected word 0 of ring entries 2..5 after the three frames
  localparam logic [31:0] EXP [4] = '{ 32'h0800_0006, 32'h0000_0008,
                                       32'h0800_0003, 32'h2801_0002 };

  logic clk, rst_n;
  logic [IDX_W-1:0] cfg_ring_start;
  logic [15:0] cfg_buf_size;
  logic act_wr; logic [31:0] act_data;
  logic host_we; logic [IDX_W:0] host_addr; logic [31:0] host_wdata, host_rdata;
  logic in_valid, in_sof, in_eof, in_err; logic [7:0] in_data;
  logic buf_we; logic [31:0] buf_addr; logic [7:0] buf_wdata;
  logic evt_frame, evt_buf, evt_overflow, active_o;

  int checks = 0, errors = 0;
  int nframe = 0, nbuf = 0;
  logic [7:0] bmem [512];
  logic [7:0] emem [512];

  rxring_engine #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rxring_engine (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (evt_frame) nframe++;
    if (evt_buf)   nbuf++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic w, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = {IDX_W'(idx), w}; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int idx, input logic w, output logic [31:0] d);
    @(negedge clk);
    host_addr = {IDX_W'(idx), w};
    #1 d = host_rdata;
  endtask

  task automatic activate();
    @(negedge clk);
    act_wr = 1'b1; act_data = 32'h0100_0000;
    @(negedge clk);
    act_wr = 1'b0; act_data = '0;
  endtask

  task automatic put_byte(input logic s, input logic e, input logic b, input logic [7:0] d,
                          output logic we);
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_err = b; in_data = d;
    #1 we = buf_we;
    if (buf_we) bmem[buf_addr[8:0]] = buf_wdata;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic we;
    int r, cnt;
    for (int i = 0; i < 512; i++) begin bmem[i] = '0; emem[i] = '0; end
    rst_n = 1'b0; cfg_ring_start = 3'd2; cfg_buf_size = 16'(BSZ);
    act_wr = 0; act_data = '0; host_we = 0; host_addr = '0; host_wdata = '0;
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!active_o && !evt_overflow && !evt_frame && !evt_buf && !buf_we, "R2 reset state",
        {28'd0, active_o, evt_overflow, evt_frame, evt_buf}, 32'd0);
    rst_n = 1'b1;

    // R1: build ring at entries 2..5, address 0x40*index, RING_END on entry 5
    for (int i = 2; i <= 5; i++) begin
      host_wr(i, 1'b1, 32'(i * 64));
      host_wr(i, 1'b0, (i == 5) ? 32'hA000_0000 : 32'h8000_0000);
    end
    host_rd(5, 1'b0, rd); chk(rd == 32'hA000_0000, "R1 host word0 readback", rd, 32'hA000_0000);
    host_rd(3, 1'b1, rd); chk(rd == 32'h0000_00C0, "R1 host word1 readback", rd, 32'h0000_00C0);

    // R9: byte before activation is dropped and flags overflow
    put_byte(1'b1, 1'b0, 1'b0, 8'hEE, we);
    chk(!we, "R9 no write while inactive", {31'd0, we}, 32'd0);
    idle();
    chk(evt_overflow, "R9 overflow raised", {31'd0, evt_overflow}, 32'd1);

    activate();
    chk(active_o && !evt_overflow, "R2 activation", {30'd0, active_o, evt_overflow}, 32'd2);

    // R3: byte without an open frame is ignored
    put_byte(1'b0, 1'b0, 1'b0, 8'h55, we);
    idle();
    chk(!we && !evt_overflow, "R3 stray byte ignored", {30'd0, we, evt_overflow}, 32'd0);

    // table walk: send the frames, modelling where each byte must land
    r = 2; cnt = 0;
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < int'(FR[f][15:0]); k++) begin
        logic last;
        last = (k == int'(FR[f][15:0]) - 1);
        put_byte(k == 0, last, FR[f][16] && last, 8'((f << 4) | k), we);
        emem[r * 64 + cnt] = 8'((f << 4) | k);
        cnt++;
        if (last || cnt == BSZ) begin
          r = (r == 5) ? 2 : r + 1;
          cnt = 0;
        end
      end
      idle();
    end
    repeat (2) @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      host_rd(i + 2, 1'b0, rd);
      chk(rd == EXP[i], "R4 R5 R6 descriptor writeback", rd, EXP[i]);
    end
    host_rd(5, 1'b1, rd); chk(rd == 32'h140, "R7 address kept on writeback", rd, 32'h140);
    begin
      int bad;
      bad = 0;
      for (int a = 128; a < 384; a++) if (bmem[a] != emem[a]) bad++;
      chk(bad == 0, "R3 buffer contents", 32'(bad), 32'd0);
    end
    chk(nframe == 3, "R5 frame events", 32'(nframe), 32'd3);
    chk(nbuf == 1, "R4 buffer-full events", 32'(nbuf), 32'd1);

    // R8: wrapped back to entry 2, still host-owned -> engine stops
    chk(!active_o, "R8 stall on host-owned descriptor", {31'd0, active_o}, 32'd0);
    put_byte(1'b1, 1'b0, 1'b0, 8'h77, we);
    idle();
    chk(!we && evt_overflow, "R9 drop while stalled", {30'd0, we, evt_overflow}, 32'd1);

    // R7: return entry 2, reactivate, next frame must land at entry 2 (address 0x80)
    host_wr(2, 1'b0, 32'h8000_0000);
    activate();
    chk(active_o && !evt_overflow, "R2 reactivation clears overflow",
        {30'd0, active_o, evt_overflow}, 32'd2);
    for (int k = 0; k < 3; k++) begin
      put_byte(k == 0, k == 2, 1'b0, 8'h30 + 8'(k), we);
    end
    idle();
    @(negedge clk);
    chk(bmem[128] == 8'h30 && bmem[130] == 8'h32, "R7 wrap to ring start",
        {16'd0, bmem[128], bmem[130]}, 32'h3032);
    host_rd(2, 1'b0, rd); chk(rd == 32'h0800_0003, "R7 R5 entry reused", rd, 32'h0800_0003);
    chk(nframe == 4, "R5 frame event after restart", 32'(nframe), 32'd4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule